// File: doc/BRIEF.md
# Conditional Trap Compare Unit

This block decides whether a conditional trap instruction should fire. On each cycle in which the valid strobe is high it takes two operands, a five-bit condition mask and a width select. It evaluates five relations between the operands: signed less-than, signed greater-than, equality, unsigned less-than and unsigned greater-than. Each relation is gated by its own mask bit. If any gated relation holds, the block raises a trap request one cycle later, together with a fixed cause code that marks a program-class exception of the trap kind.

The width select chooses between word and doubleword comparison. In word mode only the low 32 bits of each operand take part, and bit 31 supplies the sign. The upper half is ignored entirely. In doubleword mode all 64 bits are compared and bit 63 supplies the sign. Instruction decode, exception vectoring and return-address capture are handled by the surrounding pipeline. This unit only evaluates the condition and reports the result.

Top module: `trap_cmp_unit`

## Requirements
- R1: Mask bit 4 (value 0x10) enables a trap when operand A is less than operand B, both read as two's-complement signed values.
- R2: Mask bit 3 (value 0x08) enables a trap when operand A is greater than operand B, read as signed.
- R3: Mask bit 2 (value 0x04) enables a trap when operand A equals operand B over the compared width.
- R4: Mask bit 1 (value 0x02) enables a trap when A is below B as unsigned, and mask bit 0 (value 0x01) enables a trap when A is above B as unsigned.
- R5: The trap decision is the OR of all mask-gated relations. A mask of 0x00 never traps, and a mask of 0x1F always traps.
- R6: With `wide_i` low (word mode), only bits 31:0 of each operand are compared, with sign from bit 31. Bits 63:32 have no effect on the result.
- R7: With `wide_i` high (doubleword mode), all 64 bits are compared, with sign from bit 63.
- R8: A strobe sampled with `valid_i` high at a rising edge yields `trap_req_o` high during the following cycle only, if the condition holds. `trap_req_o` is never high in a cycle that does not follow a valid sample. Back-to-back strobes give back-to-back results.
- R9: While `trap_req_o` is high, `cause_o` equals 8'h71: program class 4'h7 in bits 7:4 and trap sub-cause 4'h1 in bits 3:0. While `trap_req_o` is low, `cause_o` is 8'h00.
- R10: While `rst_ni` is low, and in the first cycle after its release, `trap_req_o` is 0 and `cause_o` is 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Synchronous active-low reset |
| valid_i | input | 1 | Sample strobe for operands, mask and width |
| wide_i | input | 1 | 1 = doubleword compare, 0 = word compare |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B |
| mask_i | input | 5 | Condition mask; bit 4 = signed lt, 3 = signed gt, 2 = eq, 1 = unsigned lt, 0 = unsigned gt |
| trap_req_o | output | 1 | Registered one-cycle trap request |
| cause_o | output | 8 | Registered cause code, valid with trap_req_o |

## Verification
Two of the block's functions meet in one cycle in two ways. First, several relations can be true together: -1 against 0 is signed-less and unsigned-greater at once. The bench provokes this with operand pairs whose signed and unsigned orderings disagree, swept over all 32 masks. The result is judged by a behavioural model that forms each relation independently and ORs them. Second, a new strobe is sampled in the same cycle that the previous result is presented. The bench drives strobes back to back and with gaps between them, and compares the request and cause against the model every clock, so a stale or stretched pulse is caught.

// File: rtl/trap_cmp_pkg.sv
package trap_cmp_pkg;

    // Operand geometry
    localparam int XLEN   = 64;
    localparam int WORD_W = 32;

    // Condition vector: one bit per relation; positions are decoded by the mask
    localparam int COND_W  = 5;
    localparam int REL_GTU = 0;
    localparam int REL_LTU = 1;
    localparam int REL_EQ  = 2;
    localparam int REL_GTS = 3;
    localparam int REL_LTS = 4;

    // Cause code layout: class in the upper nibble, sub-cause in the lower
    localparam int CLASS_W = 4;
    localparam int SUB_W   = 4;
    localparam int CAUSE_W = CLASS_W + SUB_W;

    localparam logic [CLASS_W-1:0] CLASS_PROGRAM = 4'h7;
    localparam logic [SUB_W-1:0]   SUB_TRAP      = 4'h1;
    localparam logic [CAUSE_W-1:0] TRAP_CAUSE    = {CLASS_PROGRAM, SUB_TRAP};

    typedef struct packed {
        logic               req;
        logic [CAUSE_W-1:0] cause;
    } trap_out_t;

endpackage

// File: rtl/trap_operand_fit.sv
// Fits one raw operand to the selected compare width, producing a
// sign-extended view for signed relations and a zero-extended view for
// unsigned ones.
module trap_operand_fit #(
    parameter int XLEN   = 64,
    parameter int WORD_W = 32
) (
    input  logic [XLEN-1:0] raw_i,
    input  logic            wide_i,
    output logic [XLEN-1:0] sext_o,
    output logic [XLEN-1:0] zext_o
);
    localparam int PAD_W = XLEN - WORD_W;

    logic [WORD_W-1:0] low_part;
    logic              low_sign;

    assign low_part = raw_i[WORD_W-1:0];
    assign low_sign = raw_i[WORD_W-1];

    always_comb begin
        if (wide_i) begin
            sext_o = raw_i;
            zext_o = raw_i;
        end else begin
            sext_o = {{PAD_W{low_sign}}, low_part};
            zext_o = {{PAD_W{1'b0}}, low_part};
        end
    end
endmodule

// File: rtl/trap_relations.sv
// Evaluates the five operand relations with a single borrow chain per view.
module trap_relations
    import trap_cmp_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]   sa_i,
    input  logic [XLEN-1:0]   sb_i,
    input  logic [XLEN-1:0]   ua_i,
    input  logic [XLEN-1:0]   ub_i,
    output logic [COND_W-1:0] rel_o
);
    localparam int MSB = XLEN - 1;

    logic [XLEN:0] udiff;
    logic [XLEN:0] sdiff;
    logic          ult;
    logic          same_sign;
    logic          slt;
    logic          eq;

    // Borrow out of an unsigned subtraction marks "below"
    assign udiff = {1'b0, ua_i} - {1'b0, ub_i};
    assign sdiff = {1'b0, sa_i} - {1'b0, sb_i};
    assign ult   = udiff[XLEN];
    assign eq    = (ua_i == ub_i);

    // Signed: if signs differ the negative one is smaller, else the
    // magnitude ordering of the raw bits decides
    assign same_sign = (sa_i[MSB] == sb_i[MSB]);
    assign slt       = same_sign ? sdiff[XLEN] : sa_i[MSB];

    always_comb begin
        rel_o          = '0;
        rel_o[REL_LTS] = slt;
        rel_o[REL_GTS] = !slt && !eq;
        rel_o[REL_EQ]  = eq;
        rel_o[REL_LTU] = ult;
        rel_o[REL_GTU] = !ult && !eq;
    end
endmodule

// File: rtl/trap_mask_reduce.sv
// Gates each relation with its mask bit and ORs the gated terms.
module trap_mask_reduce #(
    parameter int N = 5
) (
    input  logic [N-1:0] rel_i,
    input  logic [N-1:0] mask_i,
    output logic         hit_o
);
    logic [N-1:0] gated;

    for (genvar g = 0; g < N; g++) begin : g_gate
        assign gated[g] = rel_i[g] & mask_i[g];
    end

    assign hit_o = |gated;
endmodule

// File: rtl/trap_cmp_unit.sv
module trap_cmp_unit
    import trap_cmp_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               valid_i,
    input  logic               wide_i,
    input  logic [XLEN-1:0]    opa_i,
    input  logic [XLEN-1:0]    opb_i,
    input  logic [COND_W-1:0]  mask_i,
    output logic               trap_req_o,
    output logic [CAUSE_W-1:0] cause_o
);
    localparam int NUM_OPS = 2;

    logic [NUM_OPS-1:0][XLEN-1:0] raw_ops;
    logic [NUM_OPS-1:0][XLEN-1:0] sext_ops;
    logic [NUM_OPS-1:0][XLEN-1:0] zext_ops;
    logic [COND_W-1:0]            rel;
    logic                         hit;

    trap_out_t out_d, out_q;

    assign raw_ops[0] = opa_i;
    assign raw_ops[1] = opb_i;

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_fit
        trap_operand_fit #(
            .XLEN   (XLEN),
            .WORD_W (WORD_W)
        ) u_fit (
            .raw_i  (raw_ops[g]),
            .wide_i (wide_i),
            .sext_o (sext_ops[g]),
            .zext_o (zext_ops[g])
        );
    end

    trap_relations #(
        .XLEN (XLEN)
    ) u_rel (
        .sa_i  (sext_ops[0]),
        .sb_i  (sext_ops[1]),
        .ua_i  (zext_ops[0]),
        .ub_i  (zext_ops[1]),
        .rel_o (rel)
    );

    trap_mask_reduce #(
        .N (COND_W)
    ) u_reduce (
        .rel_i  (rel),
        .mask_i (mask_i),
        .hit_o  (hit)
    );

    always_comb begin
        out_d = '0;
        if (valid_i && hit) begin
            out_d.req   = 1'b1;
            out_d.cause = TRAP_CAUSE;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign trap_req_o = out_q.req;
    assign cause_o    = out_q.cause;
endmodule

// File: rtl/trap_cmp_unit_chk.sv
module trap_cmp_unit_chk
    import trap_cmp_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic               valid_i,
    input logic               wide_i,
    input logic [XLEN-1:0]    opa_i,
    input logic [XLEN-1:0]    opb_i,
    input logic [COND_W-1:0]  mask_i,
    input logic               trap_req_o,
    input logic [CAUSE_W-1:0] cause_o
);
    AST_REQ_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_req_o |-> $past(valid_i));                                          // R8
    AST_IDLE_NO_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> !trap_req_o);                                               // R8
    AST_ZERO_MASK_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && mask_i == 5'h00) |=> !trap_req_o);                           // R5
    AST_FULL_MASK_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && mask_i == 5'h1F) |=> trap_req_o);                            // R5
    AST_EQ_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && mask_i[2] && wide_i && opa_i == opb_i) |=> trap_req_o);      // R3
    AST_WORD_EQ_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && mask_i[2] && !wide_i && opa_i[31:0] == opb_i[31:0])
        |=> trap_req_o);                                                         // R6
    AST_CAUSE_WITH_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_req_o |-> cause_o == TRAP_CAUSE);                                   // R9
    AST_CAUSE_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !trap_req_o |-> cause_o == '0);                                          // R9
endmodule

bind trap_cmp_unit trap_cmp_unit_chk u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .wide_i     (wide_i),
    .opa_i      (opa_i),
    .opb_i      (opb_i),
    .mask_i     (mask_i),
    .trap_req_o (trap_req_o),
    .cause_o    (cause_o)
);

// File: tb/trap_cmp_unit_test.sv
`timescale 1ns/1ps
module trap_cmp_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic        wide = 1'b0;
    logic [63:0] opa = '0;
    logic [63:0] opb = '0;
    logic [4:0]  mask = '0;
    logic        trap_req;
    logic [7:0]  cause;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    running = 1'b0;
    bit    done    = 1'b0;
    string cur_tag = "R8";

    logic  exp_req = 1'b0;
    string exp_tag = "R10";

    always #2.5 clk = ~clk;

    trap_cmp_unit uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .valid_i    (valid),
        .wide_i     (wide),
        .opa_i      (opa),
        .opb_i      (opb),
        .mask_i     (mask),
        .trap_req_o (trap_req),
        .cause_o    (cause)
    );

    // Behavioural reference: relations taken on integer views of the operands
    function automatic bit model(input logic [63:0] a, input logic [63:0] b,
                                 input logic [4:0] m, input bit w);
        longint          sa, sb;
        longint unsigned ua, ub;
        bit              t;
        if (w) begin
            sa = $signed(a); sb = $signed(b);
            ua = a;          ub = b;
        end else begin
            sa = longint'($signed(a[31:0]));
            sb = longint'($signed(b[31:0]));
            ua = {32'h0, a[31:0]};
            ub = {32'h0, b[31:0]};
        end
        t = 1'b0;
        if (m[4] && sa <  sb) t = 1'b1;  // R1
        if (m[3] && sa >  sb) t = 1'b1;  // R2
        if (m[2] && ua == ub) t = 1'b1;  // R3
        if (m[1] && ua <  ub) t = 1'b1;  // R4
        if (m[0] && ua >  ub) t = 1'b1;  // R4
        return t;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_req <= 1'b0;
            exp_tag <= "R10";
        end else begin
            exp_req <= valid && model(opa, opb, mask, wide);
            exp_tag <= valid ? cur_tag : "R8";
        end
    end

    always @(negedge clk) begin
        if (running && !done) begin
            n_tests++;
            if (trap_req !== exp_req || cause !== (exp_req ? 8'h71 : 8'h00)) begin
                n_fail++;
                $display("FAIL %s/R9: req=%0b cause=%h expected req=%0b cause=%h",
                         exp_tag, trap_req, cause, exp_req,
                         exp_req ? 8'h71 : 8'h00);
            end
        end
    end

    task automatic op(input logic [63:0] a, input logic [63:0] b,
                      input logic [4:0] m, input bit w, input string tag);
        @(negedge clk);
        valid = 1'b1; opa = a; opb = b; mask = m; wide = w; cur_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid = 1'b0;
            mask  = 5'h1F;
            opa   = {$urandom(), $urandom()};
            opb   = opa;
            cur_tag = "R8";
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #1000000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] bnd[2][4];
        bnd[0][0] = 64'h0;
        bnd[0][1] = 64'hFFFF_FFFF_FFFF_FFFF;
        bnd[0][2] = 64'hAAAA_5555_8000_0000;  // word min, junk above
        bnd[0][3] = 64'h1234_5678_7FFF_FFFF;  // word max, junk above
        bnd[1][0] = 64'h0;
        bnd[1][1] = 64'hFFFF_FFFF_FFFF_FFFF;
        bnd[1][2] = 64'h8000_0000_0000_0000;
        bnd[1][3] = 64'h7FFF_FFFF_FFFF_FFFF;

        // R10: outputs idle during reset
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            valid = 1'b1; mask = 5'h1F;
            n_tests++;
            if (trap_req !== 1'b0 || cause !== 8'h00) begin
                n_fail++;
                $display("FAIL R10: req=%0b cause=%h expected req=0 cause=00",
                         trap_req, cause);
            end
        end
        @(negedge clk);
        valid = 1'b0;
        rst_n = 1'b1;
        running = 1'b1;
        idle(2);

        // Single relations, doubleword
        op(64'hFFFF_FFFF_FFFF_FFFE, 64'h1, 5'h10, 1'b1, "R1");
        op(64'h5, 64'h5, 5'h10, 1'b1, "R1");
        op(64'h1, 64'h8000_0000_0000_0000, 5'h08, 1'b1, "R2");
        op(64'h8000_0000_0000_0000, 64'h1, 5'h08, 1'b1, "R2");
        op(64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0001, 5'h04, 1'b1, "R3");
        op(64'hDEAD_BEEF_0000_0001, 64'hDEAD_BEEF_0000_0000, 5'h04, 1'b1, "R3");
        op(64'h1, 64'hFFFF_FFFF_FFFF_FFFF, 5'h02, 1'b1, "R4");
        op(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'h01, 1'b1, "R4");
        op(64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 5'h02, 1'b1, "R4");
        idle(1);

        // Word mode: upper halves differ but must not matter
        op(64'h0000_0001_0000_0007, 64'hFFFF_0000_0000_0007, 5'h04, 1'b0, "R6");
        op(64'h7FFF_FFFF_8000_0000, 64'h0000_0000_0000_0001, 5'h10, 1'b0, "R6");
        op(64'h7FFF_FFFF_8000_0000, 64'h0000_0000_0000_0001, 5'h10, 1'b1, "R7");
        op(64'h0000_0000_FFFF_FFFF, 64'h0000_0001_0000_0000, 5'h02, 1'b0, "R6");
        op(64'h0000_0000_FFFF_FFFF, 64'h0000_0001_0000_0000, 5'h02, 1'b1, "R7");
        idle(2);

        // R5: mask extremes with random operands
        for (int i = 0; i < 200; i++) begin
            op({$urandom(), $urandom()}, {$urandom(), $urandom()}, 5'h00,
               1'(i % 2), "R5");
            op({$urandom(), $urandom()}, {$urandom(), $urandom()}, 5'h1F,
               1'(i % 2), "R5");
        end

        // Boundary values, every mask, both widths (R6 word / R7 doubleword)
        for (int w = 0; w < 2; w++) begin
            for (int m = 0; m < 32; m++) begin
                for (int i = 0; i < 4; i++) begin
                    for (int j = 0; j < 4; j++) begin
                        op(bnd[w][i], bnd[w][j], 5'(m), 1'(w), w ? "R7" : "R6");
                    end
                end
                if (m % 4 == 3) idle(1);
            end
        end

        // Random operands and masks, with strobe gaps (R8)
        for (int i = 0; i < 2000; i++) begin
            logic [63:0] a;
            logic [63:0] b;
            a = {$urandom(), $urandom()};
            b = ($urandom_range(0, 3) == 0) ? a : {$urandom(), $urandom()};
            if ($urandom_range(0, 3) == 0) b[63:32] = ~a[63:32];
            op(a, b, 5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)), "R5");
            if ($urandom_range(0, 4) == 0) idle($urandom_range(1, 3));
        end

        idle(3);
        finish_run();
    end
endmodule